// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block takes a single-cycle trap event from a 32-bit processor pipeline and computes everything that changes when the trap is taken. The event carries an interrupt-or-exception flag, a 4-bit cause code, the faulting address and the PC of the trapping instruction. The block chooses the privilege level that handles the trap, using the current privilege and the two delegation masks. It rewrites the environment-call cause according to the privilege it was raised from. It selects the trap value and applies the status-register side effects. It also forms the handler address, which is vectored for interrupts when the trap-vector mode field asks for it.

All results are registered. They appear one clock after the event, together with a one-cycle `valid_o` strobe, and are held until the next event. The surrounding core writes the cause, exception PC and trap value into the register set of the level that `priv_o` names. It adopts `status_o` as its new status word and fetches from `next_pc_o`.

Privilege encoding throughout: user = 0, supervisor = 1, machine = 3.

Top module: `trap_entry_unit`

## Requirements
- R1: While `rst_ni` is low and until the first trap after reset, `priv_o` is 3 (machine), `valid_o` is 0, and `status_o`, `cause_o`, `epc_o`, `tval_o` and `next_pc_o` are 0.
- R2: `valid_o` is 1 in exactly the cycle after a cycle with `trap_valid_i` high. In every other cycle it is 0, and all other outputs hold their values regardless of input changes.
- R3: The trap is handled in supervisor mode (`priv_o` = 1) when `priv_i` is 0 or 1 and bit [cause] of the delegation mask is set. Interrupts (`async_i` = 1) use `ideleg_i` and exceptions use `edeleg_i`. Otherwise the trap is handled in machine mode (`priv_o` = 3).
- R4: For an exception with cause 0, 1, 4, 5, 6, 7, 12, 13 or 15 (misaligned, access-fault and page-fault causes), `tval_o` equals `badaddr_i`. For any other exception cause, and for every interrupt, `tval_o` is 0.
- R5: An exception with cause 8 (environment call) is rewritten by `priv_i`: 0 gives 8, 1 gives 9, 3 gives 11. The rewritten cause is used for delegation, the cause output and the trap value. Interrupt cause 8 is not rewritten.
- R6: `cause_o` holds the (rewritten) cause in its low 4 bits, `async_i` in bit 31, and zeros elsewhere.
- R7: `epc_o` equals `pc_i` of the trap.
- R8: On supervisor entry, `status_o` equals `status_i` with three changes: bit 5 takes bit 1, bit 8 takes `priv_i[0]`, and bit 1 is cleared.
- R9: On machine entry, `status_o` equals `status_i` with three changes: bit 7 takes bit 3, bits 12:11 take `priv_i`, and bit 3 is cleared.
- R10: `next_pc_o` is the handling level's vector register (`stvec_i` or `mtvec_i`) with bits 1:0 cleared. 4 × cause is added only for interrupts whose vector bits 1:0 equal 1. Exceptions, and the mode values 0, 2 and 3, add nothing.
- R11: A trap raised from machine mode is handled in machine mode even when its delegation bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | Trap event strobe, one cycle per trap |
| async_i | input | 1 | 1 for interrupt, 0 for exception |
| cause_i | input | 4 | Cause code |
| badaddr_i | input | 32 | Faulting address |
| pc_i | input | 32 | PC of the trapping instruction |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| status_i | input | 32 | Current status word |
| edeleg_i | input | 32 | Exception delegation mask |
| ideleg_i | input | 32 | Interrupt delegation mask |
| stvec_i | input | 32 | Supervisor trap vector (bits 1:0 mode) |
| mtvec_i | input | 32 | Machine trap vector (bits 1:0 mode) |
| valid_o | output | 1 | Results updated this cycle |
| priv_o | output | 2 | New privilege |
| status_o | output | 32 | Updated status word |
| cause_o | output | 32 | Cause value for the handling level |
| epc_o | output | 32 | Exception PC for the handling level |
| tval_o | output | 32 | Trap value for the handling level |
| next_pc_o | output | 32 | Handler address |

## Verification
Every result is computed combinationally from the inputs sampled at the trap edge and passes through one register. All outputs, `valid_o` included, are therefore due exactly one clock after the edge that sees `trap_valid_i` high. The bench drives each event on a falling edge and holds it for one full cycle. It reads every output on the next falling edge, which is half a cycle after the capturing edge. For the hold behaviour it changes all inputs with the strobe low, then reads the outputs one falling edge later.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef logic [1:0] priv_t;
  localparam priv_t PRIV_U = 2'd0;
  localparam priv_t PRIV_S = 2'd1;
  localparam priv_t PRIV_M = 2'd3;

  // status word bit positions
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;  // two bits: 12:11

  localparam int CAUSE_ECALL = 8;
endpackage

// File: rtl/trap_cause_xlate.sv
module trap_cause_xlate
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  priv_t              priv_i,
  input  logic [XLEN-1:0]    badaddr_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    tval_o
);
  logic addr_cause;

  always_comb begin
    cause_o = cause_i;
    if (!async_i && cause_i == CAUSE_W'(CAUSE_ECALL))
      cause_o = CAUSE_W'(CAUSE_ECALL) | CAUSE_W'(priv_i);
  end

  always_comb begin
    case (int'(cause_i))
      0, 1, 4, 5, 6, 7, 12, 13, 15: addr_cause = 1'b1;
      default:                      addr_cause = 1'b0;
    endcase
  end

  assign tval_o = (!async_i && addr_cause) ? badaddr_i : '0;
endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  priv_t              priv_i,
  input  logic [XLEN-1:0]    edeleg_i,
  input  logic [XLEN-1:0]    ideleg_i,
  output logic               to_super_o
);
  logic [XLEN-1:0] mask;
  logic            bit_set;

  assign mask    = async_i ? ideleg_i : edeleg_i;
  assign bit_set = (int'(cause_i) < XLEN) ? mask[cause_i] : 1'b0;
  assign to_super_o = (priv_i <= PRIV_S) && bit_set;
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic [XLEN-1:0]    tvec_i,
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [XLEN-1:0]    pc_o
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;

  assign base = {tvec_i[XLEN-1:2], 2'b00};
  assign offs = (async_i && tvec_i[1:0] == 2'b01) ? XLEN'({cause_i, 2'b00}) : '0;
  assign pc_o = base + offs;
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_valid_i,
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    badaddr_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [1:0]         priv_i,
  input  logic [XLEN-1:0]    status_i,
  input  logic [XLEN-1:0]    edeleg_i,
  input  logic [XLEN-1:0]    ideleg_i,
  input  logic [XLEN-1:0]    stvec_i,
  input  logic [XLEN-1:0]    mtvec_i,
  output logic               valid_o,
  output logic [1:0]         priv_o,
  output logic [XLEN-1:0]    status_o,
  output logic [XLEN-1:0]    cause_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    tval_o,
  output logic [XLEN-1:0]    next_pc_o
);
  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  logic [CAUSE_W-1:0] eff_cause;
  logic [XLEN-1:0]    tval_d;
  logic               to_super;
  logic [XLEN-1:0]    tvec_sel;
  logic [XLEN-1:0]    pc_d;
  logic [XLEN-1:0]    status_d;

  trap_cause_xlate #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_xlate (
    .async_i  (async_i),
    .cause_i  (cause_i),
    .priv_i   (priv_i),
    .badaddr_i(badaddr_i),
    .cause_o  (eff_cause),
    .tval_o   (tval_d)
  );

  trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
    .async_i   (async_i),
    .cause_i   (eff_cause),
    .priv_i    (priv_i),
    .edeleg_i  (edeleg_i),
    .ideleg_i  (ideleg_i),
    .to_super_o(to_super)
  );

  assign tvec_sel = to_super ? stvec_i : mtvec_i;

  trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
    .tvec_i (tvec_sel),
    .async_i(async_i),
    .cause_i(eff_cause),
    .pc_o   (pc_d)
  );

  always_comb begin
    status_d = status_i;
    if (to_super) begin
      status_d[ST_SPIE] = status_i[ST_SIE];
      status_d[ST_SPP]  = priv_i[0];
      status_d[ST_SIE]  = 1'b0;
    end else begin
      status_d[ST_MPIE]          = status_i[ST_MIE];
      status_d[ST_MPP+1:ST_MPP]  = priv_i;
      status_d[ST_MIE]           = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      priv_o    <= PRIV_M;
      status_o  <= '0;
      cause_o   <= '0;
      epc_o     <= '0;
      tval_o    <= '0;
      next_pc_o <= '0;
    end else begin
      valid_o <= trap_valid_i;
      if (trap_valid_i) begin
        priv_o    <= to_super ? PRIV_S : PRIV_M;
        status_o  <= status_d;
        cause_o   <= {async_i, {PAD_W{1'b0}}, eff_cause};
        epc_o     <= pc_i;
        tval_o    <= tval_d;
        next_pc_o <= pc_d;
      end
    end
  end

  // assertions
  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> valid_o);
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_valid_i |=> (!valid_o && $stable(priv_o) && $stable(next_pc_o) && $stable(status_o)));
  assert_target_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (priv_o == PRIV_S || priv_o == PRIV_M));
  assert_machine_stays_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && priv_i == PRIV_M) |=> priv_o == PRIV_M);
  assert_int_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> cause_o[XLEN-1] == $past(async_i));
  assert_epc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_i |=> epc_o == $past(pc_i));
  assert_sie_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && priv_o == PRIV_S) |-> !status_o[ST_SIE]);
  assert_mie_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && priv_o == PRIV_M) |-> !status_o[ST_MIE]);
  assert_pc_aligned_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> next_pc_o[1:0] == 2'b00);
endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0;
  logic        async_f = 1'b0;
  logic [3:0]  cause = '0;
  logic [31:0] badaddr = '0, pc = '0, status = '0, edeleg = '0, ideleg = '0;
  logic [31:0] stvec = '0, mtvec = '0;
  logic [1:0]  priv = '0;
  logic        valid;
  logic [1:0]  priv_q;
  logic [31:0] status_q, cause_q, epc_q, tval_q, npc_q;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(trap_valid), .async_i(async_f),
    .cause_i(cause), .badaddr_i(badaddr), .pc_i(pc), .priv_i(priv),
    .status_i(status), .edeleg_i(edeleg), .ideleg_i(ideleg),
    .stvec_i(stvec), .mtvec_i(mtvec), .valid_o(valid), .priv_o(priv_q),
    .status_o(status_q), .cause_o(cause_q), .epc_o(epc_q), .tval_o(tval_q),
    .next_pc_o(npc_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive one trap on a falling edge, return on the next falling edge
  task automatic fire(input logic a, input logic [3:0] c, input logic [1:0] p,
                      input logic [31:0] st, input logic [31:0] ed, input logic [31:0] id,
                      input logic [31:0] sv, input logic [31:0] mv,
                      input logic [31:0] pcv, input logic [31:0] ba);
    @(negedge clk);
    async_f = a; cause = c; priv = p; status = st; edeleg = ed; ideleg = id;
    stvec = sv; mtvec = mv; pc = pcv; badaddr = ba; trap_valid = 1'b1;
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", {31'd0, valid}, 32'd0);
    chk("R1 priv", {30'd0, priv_q}, 32'd3);
    chk("R1 status", status_q, 32'd0);
    chk("R1 cause", cause_q, 32'd0);
    chk("R1 epc", epc_q, 32'd0);
    chk("R1 tval", tval_q, 32'd0);
    chk("R1 npc", npc_q, 32'd0);
  endtask

  task automatic t_sync_super;
    // user load page fault delegated; stvec mode 1 ignored for exceptions
    fire(1'b0, 4'd13, 2'd0, 32'h0008_0002, 32'h0000_2000, 32'h0, 32'h8000_0101,
         32'h0000_5000, 32'h1000_0040, 32'hDEAD_BEE0);
    chk("R2 valid", {31'd0, valid}, 32'd1);
    chk("R3 priv S", {30'd0, priv_q}, 32'd1);
    chk("R4 tval addr", tval_q, 32'hDEAD_BEE0);
    chk("R6 cause", cause_q, 32'd13);
    chk("R7 epc", epc_q, 32'h1000_0040);
    chk("R8 status", status_q, 32'h0008_0020);
    chk("R10 npc sync no vector", npc_q, 32'h8000_0100);
  endtask

  task automatic t_hold;
    @(negedge clk);
    async_f = 1'b1; cause = 4'd3; priv = 2'd3; status = 32'hFFFF_FFFF;
    mtvec = 32'h7777_0001; stvec = 32'h6666_0001; pc = 32'h1234_5678;
    @(negedge clk);
    chk("R2 valid low", {31'd0, valid}, 32'd0);
    chk("R2 priv hold", {30'd0, priv_q}, 32'd1);
    chk("R2 npc hold", npc_q, 32'h8000_0100);
    chk("R2 cause hold", cause_q, 32'd13);
    chk("R2 status hold", status_q, 32'h0008_0020);
  endtask

  task automatic t_async_machine_vectored;
    fire(1'b1, 4'd7, 2'd1, 32'h0000_0008, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0,
         32'h0000_1001, 32'h0000_0200, 32'h1111_1111);
    chk("R3 priv M", {30'd0, priv_q}, 32'd3);
    chk("R4 tval int zero", tval_q, 32'd0);
    chk("R6 cause int", cause_q, 32'h8000_0007);
    chk("R9 status", status_q, 32'h0000_0880);
    chk("R10 npc vectored", npc_q, 32'h0000_101C);
  endtask

  task automatic t_async_super_mask;
    // interrupt uses ideleg, not edeleg
    fire(1'b1, 4'd5, 2'd0, 32'h0, 32'h0, 32'h0000_0020, 32'h0000_2001,
         32'h0000_9000, 32'h0000_0300, 32'h0);
    chk("R3 ideleg S", {30'd0, priv_q}, 32'd1);
    chk("R10 npc S vectored", npc_q, 32'h0000_2014);
    chk("R8 status zero", status_q, 32'h0);
  endtask

  task automatic t_sync_mask;
    // exception uses edeleg, ideleg bit ignored; cause 2 carries no address
    fire(1'b0, 4'd2, 2'd0, 32'h0, 32'h0, 32'h0000_0004, 32'h0000_8000,
         32'h0000_3000, 32'h0000_0400, 32'hABCD_0000);
    chk("R3 edeleg M", {30'd0, priv_q}, 32'd3);
    chk("R4 tval non addr", tval_q, 32'd0);
    chk("R10 npc direct", npc_q, 32'h0000_3000);
  endtask

  task automatic t_machine_deleg;
    fire(1'b0, 4'd5, 2'd3, 32'h0000_0008, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_8000,
         32'h0000_4000, 32'h0000_0500, 32'h0000_0ABC);
    chk("R11 priv M", {30'd0, priv_q}, 32'd3);
    chk("R9 status MPP=3", status_q, 32'h0000_1880);
    chk("R4 tval load access", tval_q, 32'h0000_0ABC);
  endtask

  task automatic t_ecall;
    fire(1'b0, 4'd8, 2'd0, 32'h0, 32'h0000_0100, 32'h0, 32'h0000_8000,
         32'h0000_4000, 32'h0, 32'h5555_5555);
    chk("R5 U ecall cause", cause_q, 32'd8);
    chk("R5 U ecall to S", {30'd0, priv_q}, 32'd1);
    chk("R4 ecall tval", tval_q, 32'd0);
    fire(1'b0, 4'd8, 2'd1, 32'h0, 32'h0000_0100, 32'h0, 32'h0000_8000,
         32'h0000_4000, 32'h0, 32'h0);
    chk("R5 S ecall cause", cause_q, 32'd9);
    chk("R5 S ecall bit8 unused", {30'd0, priv_q}, 32'd3);
    chk("R9 MPP=1", status_q, 32'h0000_0800);
    fire(1'b0, 4'd8, 2'd1, 32'h0, 32'h0000_0200, 32'h0, 32'h0000_8000,
         32'h0000_4000, 32'h0, 32'h0);
    chk("R5 S ecall bit9", {30'd0, priv_q}, 32'd1);
    chk("R8 SPP=1", status_q, 32'h0000_0100);
    fire(1'b0, 4'd8, 2'd3, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_4000, 32'h0, 32'h0);
    chk("R5 M ecall cause", cause_q, 32'd11);
    fire(1'b1, 4'd8, 2'd1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_4000, 32'h0, 32'h0);
    chk("R5 int 8 not rewritten", cause_q, 32'h8000_0008);
  endtask

  task automatic t_vec_modes;
    fire(1'b1, 4'd11, 2'd3, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_4002, 32'h0, 32'h0);
    chk("R10 mode 2 no offset", npc_q, 32'h0000_4000);
    fire(1'b1, 4'd15, 2'd3, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_4001, 32'h0, 32'h0);
    chk("R10 mode 1 cause 15", npc_q, 32'h0000_403C);
    fire(1'b0, 4'd15, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0000_4001, 32'h0, 32'h0000_0F00);
    chk("R4 store page tval", tval_q, 32'h0000_0F00);
    chk("R10 exc mode 1 no offset", npc_q, 32'h0000_4000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sync_super();
    t_hold();
    t_async_machine_vectored();
    t_async_super_mask();
    t_sync_mask();
    t_machine_deleg();
    t_ecall();
    t_vec_modes();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule